// File: doc/BRIEF.md
# Bus Time-out and Watchdog Monitor

This block holds two supervisory timers that sit beside a processor bus. The first timer watches each bus cycle and raises a time-out flag when a cycle stays busy without an acknowledge for a programmable number of clocks. The limit is either 64 or 128 clocks. The second timer is a watchdog. It counts down from a 16-bit setup value that software loads. Software must restart it with a kick strobe before it runs out, or the watchdog flag is raised.

The watchdog decrements on one of two tick sources. The fast source is a 1 MHz tick made by dividing the system clock by a programmed clock frequency in MHz. The slow source is an external 1 kHz pulse input. Both flags are sticky. Software clears them by writing to a status-clear address. Either flag drives the interrupt request. Configuration comes through a simple write port with three addresses.

Top module: `bus_wdog_monitor`

## Requirements
- R1: After a synchronous active-low reset, both flags and irq are 0. The control word and the watchdog setup count are 0.
- R2: The bus timer counts only while control bit 6 (time-out enable) is 1. With the bit at 0, no time-out is ever flagged.
- R3: With control bit 7 at 0, bto_flag is set by the 64th consecutive clock edge that samples bus_busy=1 and bus_ack=0. With bit 7 at 1, it is set by the 128th such edge. It is not set earlier.
- R4: An edge that samples bus_ack=1 or bus_busy=0 returns the bus timer to zero, so the full limit is needed again.
- R5: The watchdog runs only while control bit 8 is 1. While the bit is 0, no watchdog event occurs, and the counter is held at the setup count (address 1, bits 15:0).
- R6: With control bit 9 at 0, the watchdog ticks once every P clocks, where P is control bits 5:0 (a value of 0 is treated as 1). With setup N, wdt_flag is set by the clock edge that carries the N-th tick after enabling. Once the count has reached zero it does not fire again until it is reloaded.
- R7: A wd_kick pulse reloads the watchdog counter with the setup count. Kicking more often than the expiry interval keeps wdt_flag at 0.
- R8: With control bit 9 at 1, the watchdog decrements only on edges that sample tick_1khz=1, and the divided clock tick is ignored.
- R9: The flags are sticky. A write to address 2 clears bto_flag where data bit 0 is 1 and wdt_flag where data bit 1 is 1. A new event in the same cycle as its clear wins.
- R10: irq is 1 exactly when at least one flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_busy | input | 1 | A bus cycle is in progress |
| bus_ack | input | 1 | Acknowledge for the current bus cycle |
| wd_kick | input | 1 | Watchdog reload strobe |
| tick_1khz | input | 1 | One-clock pulse from the 1 kHz reference |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 setup, 2 status clear |
| reg_wdata | input | 16 | Register write data |
| bto_flag | output | 1 | Sticky bus time-out flag |
| wdt_flag | output | 1 | Sticky watchdog expiry flag |
| irq | output | 1 | Interrupt request |

## Verification
The bus timer is tried with several stalled cycles:
- A stall under each limit, sampled one edge before and on the limit edge, which separates a correct count from an off-by-one.
- A stall with the timer disabled.
- A stall broken by an acknowledge, and one broken by a one-clock drop of busy. Both must restart the count from zero.

The watchdog is tried with several tick patterns:
- Divided ticks with a period of three clocks, which pins the expiry edge to setup times period.
- A steady train of kicks that must hold the flag low.
- External pulses after switching sources, with a fast divider that would expire early if it were not ignored.

Clearing is tried bit by bit, and also against a time-out landing on the same edge as its clear.

// File: rtl/bwm_pkg.sv
// Package: shared register addresses and the control-word layout for the
// bus time-out and watchdog monitor.
package bwm_pkg;
    localparam int ADDR_W   = 2;
    localparam int DATA_W   = 16;
    localparam int MHZ_W    = 6;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_SETUP = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CLEAR = 2'd2;

    // Control word, bits 9:0 of address 0
    typedef struct packed {
        logic             wd_slow;   // bit 9: 1 = external 1 kHz ticks
        logic             wd_en;     // bit 8
        logic             bto_long;  // bit 7: 1 = long limit
        logic             bto_en;    // bit 6
        logic [MHZ_W-1:0] clk_mhz;   // bits 5:0: clocks per 1 MHz tick
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/bwm_bus_timeout.sv
// Bus time-out counter. It counts clocks while a bus cycle is outstanding
// (busy and not acknowledged) and emits a one-cycle fire pulse when the
// selected limit is reached. It saturates afterwards, so one stalled cycle
// fires once. Assumes bus_busy and bus_ack are synchronous to clk.
module bwm_bus_timeout #(
    parameter int SHORT_LIMIT = 64,
    parameter int LONG_LIMIT  = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic long_sel,
    input  logic bus_busy,
    input  logic bus_ack,
    output logic fire
);
    localparam int CNT_W = $clog2(LONG_LIMIT + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic             outstanding;

    // Select the active limit and decide whether a cycle is waiting
    always_comb begin
        limit       = long_sel ? CNT_W'(LONG_LIMIT) : CNT_W'(SHORT_LIMIT);
        outstanding = en && bus_busy && !bus_ack;
        fire        = outstanding && (cnt == limit - CNT_W'(1));
    end

    // Count waiting clocks, restart when idle or acknowledged, saturate at limit
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!outstanding)
            cnt <= '0;
        else if (cnt < limit)
            cnt <= cnt + CNT_W'(1);
    end

    assert_ack_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack || !bus_busy) |=> (cnt == '0));
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(LONG_LIMIT));
    assert_off_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0));
endmodule

// File: rtl/bwm_tick_gen.sv
// Fast watchdog tick generator. It divides the system clock by the
// programmed MHz value to give one-cycle pulses, treating 0 as 1.
// Assumes period stays stable while en is high.
module bwm_tick_gen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] period,
    output logic             tick
);
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] last;

    // Terminal value of the divider and the tick it produces
    always_comb begin
        last = (period == '0) ? '0 : period - DIV_W'(1);
        tick = en && (div_cnt == last);
    end

    // Advance the divider while enabled, wrap on tick
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick)
            div_cnt <= '0;
        else
            div_cnt <= div_cnt + DIV_W'(1);
    end

    assert_div_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $stable(period) && $past(en)) |-> (div_cnt <= last));
endmodule

// File: rtl/bwm_wdog_counter.sv
// Watchdog down-counter. It is held at the setup count while disabled or
// kicked, and decrements on each tick. It fires once when a tick takes it
// from one to zero, then stays at zero until reloaded.
module bwm_wdog_counter #(
    parameter int WD_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            kick,
    input  logic            tick,
    input  logic [WD_W-1:0] setup,
    output logic            fire
);
    logic [WD_W-1:0] count;

    // Expiry: a tick lands on the last remaining count
    always_comb fire = en && !kick && tick && (count == WD_W'(1));

    // Reload on kick or while disabled, otherwise count ticks down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (!en || kick)
            count <= setup;
        else if (tick && count != '0)
            count <= count - WD_W'(1);
    end

    assert_kick_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (count == $past(setup)));
    assert_hold_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (count == $past(setup)));
    assert_zero_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !kick && count == '0) |=> (count == '0));
endmodule

// File: rtl/bus_wdog_monitor.sv
// Bus time-out and watchdog monitor, top level. It holds the control and
// setup registers, chooses the watchdog tick source, and keeps the two
// sticky flags that form the interrupt request. Assumes tick_1khz is a
// one-clock pulse synchronous to clk.
module bus_wdog_monitor
    import bwm_pkg::*;
#(
    parameter int SHORT_LIMIT = 64,
    parameter int LONG_LIMIT  = 128,
    parameter int WD_W        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_busy,
    input  logic              bus_ack,
    input  logic              wd_kick,
    input  logic              tick_1khz,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              bto_flag,
    output logic              wdt_flag,
    output logic              irq
);
    ctrl_t           ctrl_q;
    logic [WD_W-1:0] setup_q;
    logic            bto_fire;
    logic            wd_fire;
    logic            fast_tick;
    logic            wd_tick;
    logic            clr_bto;
    logic            clr_wdt;

    // Register writes for control and setup
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            setup_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == ADDR_CTRL)  ctrl_q  <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            if (reg_addr == ADDR_SETUP) setup_q <= reg_wdata[WD_W-1:0];
        end
    end

    // Decode clear requests and pick the watchdog tick source
    always_comb begin
        clr_bto = reg_we && (reg_addr == ADDR_CLEAR) && reg_wdata[0];
        clr_wdt = reg_we && (reg_addr == ADDR_CLEAR) && reg_wdata[1];
        wd_tick = ctrl_q.wd_slow ? tick_1khz : fast_tick;
    end

    bwm_bus_timeout #(
        .SHORT_LIMIT (SHORT_LIMIT),
        .LONG_LIMIT  (LONG_LIMIT)
    ) u_bto (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctrl_q.bto_en),
        .long_sel (ctrl_q.bto_long),
        .bus_busy (bus_busy),
        .bus_ack  (bus_ack),
        .fire     (bto_fire)
    );

    bwm_tick_gen #(
        .DIV_W (MHZ_W)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ctrl_q.wd_en && !ctrl_q.wd_slow),
        .period (ctrl_q.clk_mhz),
        .tick   (fast_tick)
    );

    bwm_wdog_counter #(
        .WD_W (WD_W)
    ) u_wd (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ctrl_q.wd_en),
        .kick  (wd_kick),
        .tick  (wd_tick),
        .setup (setup_q),
        .fire  (wd_fire)
    );

    // Sticky flags: a new event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bto_flag <= 1'b0;
            wdt_flag <= 1'b0;
        end else begin
            bto_flag <= (bto_flag && !clr_bto) || bto_fire;
            wdt_flag <= (wdt_flag && !clr_wdt) || wd_fire;
        end
    end

    // Interrupt request from either flag
    always_comb irq = bto_flag || wdt_flag;

    assert_bto_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bto_flag && !clr_bto) |=> bto_flag);
    assert_wdt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_flag && !clr_wdt) |=> wdt_flag);
    assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bto_flag) || $rose(wdt_flag)) |-> irq);
    assert_bto_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.bto_en && !bto_flag) |=> !bto_flag);
endmodule

// File: tb/bus_wdog_monitor_tb.sv
module bus_wdog_monitor_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_busy = 1'b0;
    logic        bus_ack = 1'b0;
    logic        wd_kick = 1'b0;
    logic        tick_1khz = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        bto_flag;
    logic        wdt_flag;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string tag;
        logic  bto;
        logic  wdt;
        logic  irq;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    bus_wdog_monitor u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_busy  (bus_busy),
        .bus_ack   (bus_ack),
        .wd_kick   (wd_kick),
        .tick_1khz (tick_1khz),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .bto_flag  (bto_flag),
        .wdt_flag  (wdt_flag),
        .irq       (irq)
    );

    // Monitor: pop expected items and compare away from the rising edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            checks++;
            if (bto_flag !== it.bto || wdt_flag !== it.wdt || irq !== it.irq) begin
                errors++;
                $display("FAIL %s: got bto=%b wdt=%b irq=%b, expected bto=%b wdt=%b irq=%b",
                         it.tag, bto_flag, wdt_flag, irq, it.bto, it.wdt, it.irq);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_flags(input string tag, input logic b, input logic w);
        exp_t it;
        it.tag = tag;
        it.bto = b;
        it.wdt = w;
        it.irq = b | w;
        exp_q.push_back(it);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_we = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(posedge clk);
        #1;
        reg_we = 1'b0;
    endtask

    task automatic kick();
        wd_kick = 1'b1;
        @(posedge clk);
        #1;
        wd_kick = 1'b0;
    endtask

    task automatic pulse_1k();
        tick_1khz = 1'b1;
        @(posedge clk);
        #1;
        tick_1khz = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: run did not finish, got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        expect_flags("R1 reset state", 0, 0);

        // R2: timer disabled, long stall
        bus_busy = 1'b1;
        step(200);
        expect_flags("R2 disabled timer stays quiet", 0, 0);
        bus_busy = 1'b0;
        step(1);

        // R3: short limit, edge before and on the limit
        wr(2'd0, 16'h0040);
        bus_busy = 1'b1;
        step(63);
        expect_flags("R3 short limit one edge early", 0, 0);
        step(1);
        expect_flags("R3 short limit reached, R10 irq", 1, 0);
        wr(2'd2, 16'h0001);
        expect_flags("R9 clear while stall persists", 0, 0);
        step(10);
        expect_flags("R3 saturated stall fires once", 0, 0);
        bus_busy = 1'b0;
        step(1);

        // R4: acknowledge restarts the count
        bus_busy = 1'b1;
        step(50);
        bus_ack = 1'b1;
        step(1);
        bus_ack = 1'b0;
        step(63);
        expect_flags("R4 ack restarts count", 0, 0);
        step(1);
        expect_flags("R4 full limit after ack", 1, 0);
        bus_busy = 1'b0;
        wr(2'd2, 16'h0001);

        // R3: long limit
        wr(2'd0, 16'h00C0);
        bus_busy = 1'b1;
        step(127);
        expect_flags("R3 long limit one edge early", 0, 0);
        step(1);
        expect_flags("R3 long limit reached", 1, 0);
        bus_busy = 1'b0;
        wr(2'd2, 16'h0001);

        // R4: a one-clock drop of busy restarts the count
        bus_busy = 1'b1;
        step(100);
        bus_busy = 1'b0;
        step(1);
        bus_busy = 1'b1;
        step(127);
        expect_flags("R4 busy drop restarts count", 0, 0);
        bus_busy = 1'b0;
        step(1);

        // R9: event and clear on the same edge, event wins
        wr(2'd0, 16'h0040);
        bus_busy = 1'b1;
        step(63);
        wr(2'd2, 16'h0001);
        expect_flags("R9 set wins over same-edge clear", 1, 0);
        bus_busy = 1'b0;
        wr(2'd2, 16'h0001);
        expect_flags("R9 clear afterwards", 0, 0);

        // R6: fast ticks, period 3, setup 5 -> 15 edges after enable
        wr(2'd1, 16'd5);
        wr(2'd0, 16'h0103);
        step(14);
        expect_flags("R6 one edge before expiry", 0, 0);
        step(1);
        expect_flags("R6 expiry at setup times period", 0, 1);
        wr(2'd2, 16'h0002);
        step(30);
        expect_flags("R6 no refire at zero", 0, 0);

        // R7: kicks keep it alive
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'h0103);
        for (int i = 0; i < 6; i++) begin
            step(9);
            kick();
        end
        expect_flags("R7 regular kicks hold flag low", 0, 0);
        step(20);
        expect_flags("R7 expiry after kicks stop", 0, 1);

        // R5: disabled watchdog stays quiet
        wr(2'd0, 16'h0000);
        wr(2'd2, 16'h0002);
        step(100);
        expect_flags("R5 disabled watchdog quiet", 0, 0);

        // R8: external 1 kHz ticks, divided tick ignored
        wr(2'd0, 16'h0301);
        step(50);
        expect_flags("R8 divided tick ignored", 0, 0);
        for (int i = 0; i < 4; i++) begin
            pulse_1k();
            step(2);
        end
        expect_flags("R8 four pulses not enough", 0, 0);
        pulse_1k();
        expect_flags("R8 fifth pulse expires", 0, 1);

        // R9: selective clearing with both flags set
        wr(2'd0, 16'h0340);
        bus_busy = 1'b1;
        step(64);
        expect_flags("R10 both flags set", 1, 1);
        bus_busy = 1'b0;
        wr(2'd2, 16'h0002);
        expect_flags("R9 clear only watchdog bit", 1, 0);
        wr(2'd2, 16'h0001);
        expect_flags("R9 clear bus bit", 0, 0);

        step(2);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule